// File: doc/BRIEF.md
# Configurable watchdog reset timer

The block is a watchdog that raises a one-cycle system reset request when software fails to clear it in time. It is a binary up counter made of a prescaler followed by a divide-by-16 overflow stage. The prescaler counts either CPU clock-enable ticks or ticks from a low-speed RC oscillator. With the CPU clock as source, a rate bit selects a long or a short prescaler tap. With the RC clock as source, a fixed shorter prescale is used and the rate bit has no effect.

Software keeps the system alive by pulsing the clear input before the count runs out. The block counts only in normal CPU mode. In every other mode the whole count is held at zero. When the source or rate selection changes, the prescaler restarts from zero so that a count made under one setting is never finished under another.

Top module: `wdt_reset_timer`

## Requirements
- R1: After reset `resetReq` is 0. With `srcSel`=0, `rateSel`=0 and `cpuMode`=00, `resetReq` goes high after exactly 2^SLOW_LOG2 * 2^FINAL_LOG2 `cpuTick` pulses (defaults: 2^14 * 16). It is visible in the cycle after the clock edge that takes the last tick.
- R2: With `srcSel`=0 and `rateSel`=1, overflow takes exactly 2^FAST_LOG2 * 2^FINAL_LOG2 `cpuTick` pulses (defaults: 2^8 * 16).
- R3: With `srcSel`=1, overflow takes exactly 2^RC_LOG2 * 2^FINAL_LOG2 `rcTick` pulses (defaults: 512 * 16), whatever the value of `rateSel`. `cpuTick` is ignored.
- R4: With `srcSel`=0, `rcTick` is ignored.
- R5: `resetReq` is high for exactly one cycle. The whole count is zero after it, so the next overflow needs a full period again.
- R6: A clock edge with `clrStrobe`=1 clears the prescaler and the overflow stage. This takes priority over a tick in the same cycle. `clrStrobe`=0 has no effect.
- R7: When `cpuMode` is 01 (sleep), 10 (green) or 11 (reserved), the count is held at zero and ticks are ignored. After a return to 00, a full period is needed.
- R8: A change of `srcSel` or `rateSel` clears the prescaler but keeps the overflow-stage count. A tick in the cycle of the change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuTick | input | 1 | One-cycle CPU clock-enable tick |
| rcTick | input | 1 | One-cycle tick from the low-speed RC oscillator |
| srcSel | input | 1 | Count source: 0 CPU tick, 1 RC tick |
| rateSel | input | 1 | CPU-source tap: 0 long, 1 short |
| clrStrobe | input | 1 | Software clear of the whole count |
| cpuMode | input | 2 | CPU mode: 00 normal, 01 sleep, 10 green, 11 reserved |
| resetReq | output | 1 | One-cycle reset request on overflow |

## Verification
The reset request is registered, so it appears one clock edge after the tick that completes the period. The bench drives each tick at a falling edge and reads `resetReq` at the next falling edge. The pulse-width check comes one cycle later. The periods are measured by counting ticks until the first request. A request that comes early or late therefore shows up as a count mismatch, not as a missed sample. Ticks are spaced one idle cycle apart, and the unselected tick stays high through those idle cycles, so a wrongly counted source changes the measured count. Clear, mode and configuration changes are applied with no tick pending, except in the clear-priority case. There a tick and the clear share one edge, and the request is sampled at the next falling edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] MODE_NORMAL = 2'b00;

  typedef enum logic [1:0] {
    TAP_SLOW = 2'd0,
    TAP_FAST = 2'd1,
    TAP_RC   = 2'd2
  } wdtTap_e;

  typedef struct packed {
    logic    clearAll;
    logic    clearPre;
    logic    countTick;
    wdtTap_e tapSel;
  } wdtStrb_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuTick,
  input  logic       rcTick,
  input  logic       srcSel,
  input  logic       rateSel,
  input  logic       clrStrobe,
  input  logic [1:0] cpuMode,
  output wdtStrb_t   strb
);
  logic [1:0] cfgQ;
  logic       runEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= 2'b00;
    else       cfgQ <= {srcSel, rateSel};
  end

  assign runEn = (cpuMode == MODE_NORMAL);

  always_comb begin
    strb.clearAll  = clrStrobe | ~runEn;
    strb.clearPre  = (cfgQ != {srcSel, rateSel});
    strb.countTick = runEn & (srcSel ? rcTick : cpuTick);
    if (srcSel)       strb.tapSel = TAP_RC;
    else if (rateSel) strb.tapSel = TAP_FAST;
    else              strb.tapSel = TAP_SLOW;
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int SLOW_LOG2  = 14,
  parameter int FAST_LOG2  = 8,
  parameter int RC_LOG2    = 9,
  parameter int FINAL_LOG2 = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  wdtStrb_t strb,
  output logic     resetReq
);
  localparam int PRE_W_A = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam int PRE_W   = (PRE_W_A > RC_LOG2) ? PRE_W_A : RC_LOG2;
  localparam logic [PRE_W-1:0] MASK_SLOW = PRE_W'((64'd1 << SLOW_LOG2) - 64'd1);
  localparam logic [PRE_W-1:0] MASK_FAST = PRE_W'((64'd1 << FAST_LOG2) - 64'd1);
  localparam logic [PRE_W-1:0] MASK_RC   = PRE_W'((64'd1 << RC_LOG2) - 64'd1);

  logic [PRE_W-1:0]      preCnt;
  logic [FINAL_LOG2-1:0] finCnt;
  logic [PRE_W-1:0]      tapMask;
  logic                  incEn, stageCarry, overflow;

  always_comb begin
    unique case (strb.tapSel)
      TAP_FAST: tapMask = MASK_FAST;
      TAP_RC:   tapMask = MASK_RC;
      default:  tapMask = MASK_SLOW;
    endcase
  end

  assign incEn      = strb.countTick & ~strb.clearAll & ~strb.clearPre;
  assign stageCarry = incEn & ((preCnt & tapMask) == tapMask);
  assign overflow   = stageCarry & (&finCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      finCnt   <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= overflow;
      if (strb.clearAll || overflow) begin
        preCnt <= '0;
        finCnt <= '0;
      end else if (strb.clearPre) begin
        preCnt <= '0;
      end else if (stageCarry) begin
        preCnt <= '0;
        finCnt <= finCnt + 1'b1;
      end else if (incEn) begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (preCnt == '0 && finCnt == '0));
  // R1
  full_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(&finCnt));
  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (preCnt == '0 && finCnt == '0 && !resetReq));
  // R8
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearPre && !strb.clearAll) |=> (preCnt == '0 && $stable(finCnt)));
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer
  import wdt_pkg::*;
#(
  parameter int SLOW_LOG2  = 14,
  parameter int FAST_LOG2  = 8,
  parameter int RC_LOG2    = 9,
  parameter int FINAL_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuTick,
  input  logic       rcTick,
  input  logic       srcSel,
  input  logic       rateSel,
  input  logic       clrStrobe,
  input  logic [1:0] cpuMode,
  output logic       resetReq
);
  wdtStrb_t strb;

  wdt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuTick   (cpuTick),
    .rcTick    (rcTick),
    .srcSel    (srcSel),
    .rateSel   (rateSel),
    .clrStrobe (clrStrobe),
    .cpuMode   (cpuMode),
    .strb      (strb)
  );

  wdt_datapath #(
    .SLOW_LOG2  (SLOW_LOG2),
    .FAST_LOG2  (FAST_LOG2),
    .RC_LOG2    (RC_LOG2),
    .FINAL_LOG2 (FINAL_LOG2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .resetReq (resetReq)
  );
endmodule

// File: tb/sim_wdt_reset_timer.sv
module sim_wdt_reset_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 6;
  localparam int FAST = 3;
  localparam int RCL  = 4;
  localparam int FINL = 4;
  localparam int P_SLOW = (1 << SLOW) * (1 << FINL);
  localparam int P_FAST = (1 << FAST) * (1 << FINL);
  localparam int P_RC   = (1 << RCL) * (1 << FINL);

  typedef struct packed {
    logic src;
    logic rate;
    logic [31:0] expTicks;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{src: 1'b0, rate: 1'b0, expTicks: P_SLOW},
    '{src: 1'b0, rate: 1'b1, expTicks: P_FAST},
    '{src: 1'b1, rate: 1'b0, expTicks: P_RC},
    '{src: 1'b1, rate: 1'b1, expTicks: P_RC}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuTick = 1'b0, rcTick = 1'b0, srcSel = 1'b0, rateSel = 1'b0, clrStrobe = 1'b0;
  logic [1:0] cpuMode = 2'b00;
  logic resetReq;
  int total = 0, failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_reset_timer #(.SLOW_LOG2(SLOW), .FAST_LOG2(FAST), .RC_LOG2(RCL), .FINAL_LOG2(FINL)) u0 (
    .clk(clk), .rstN(rstN), .cpuTick(cpuTick), .rcTick(rcTick), .srcSel(srcSel),
    .rateSel(rateSel), .clrStrobe(clrStrobe), .cpuMode(cpuMode), .resetReq(resetReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // selected tick for one cycle, then an idle cycle with the other tick high
  task automatic oneTick(output bit seen);
    cpuTick = 1'b1; rcTick = 1'b1;
    @(negedge clk);
    seen = resetReq;
    if (srcSel) rcTick = 1'b0; else cpuTick = 1'b0;
    @(negedge clk);
    seen = seen | resetReq;
    cpuTick = 1'b0; rcTick = 1'b0;
  endtask

  task automatic measure(input int limit, output int got);
    bit s;
    got = 0;
    for (int i = 1; i <= limit && got == 0; i++) begin
      oneTick(s);
      if (s) got = i;
    end
  endtask

  task automatic setCfg(input logic s, input logic r);
    srcSel = s; rateSel = r; clrStrobe = 1'b1;
    @(negedge clk);
    clrStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic runQuiet(input int n, output int hits);
    bit s;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      oneTick(s);
      if (s) hits++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int got, hits;
    repeat (3) @(negedge clk);
    chk("R1 reset state", resetReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 default configuration straight out of reset
    measure(P_SLOW + 4, got);
    chk("R1 default period", got, P_SLOW);
    chk("R5 pulse width", resetReq, 0);

    // table walk: R1 R2 R3 R4
    foreach (VECS[k]) begin
      setCfg(VECS[k].src, VECS[k].rate);
      measure(VECS[k].expTicks + 4, got);
      chk($sformatf("R1/R2/R3/R4 vec%0d period", k), got, VECS[k].expTicks);
      chk($sformatf("R5 vec%0d pulse width", k), resetReq, 0);
    end

    // R5 the next period is full again
    measure(P_RC + 4, got);
    chk("R5 second period", got, P_RC);

    // R6 clear with a tick in the same cycle
    setCfg(1'b0, 1'b1);
    runQuiet(P_FAST - 1, hits);
    chk("R6 no early request", hits, 0);
    cpuTick = 1'b1; clrStrobe = 1'b1;
    @(negedge clk);
    cpuTick = 1'b0; clrStrobe = 1'b0;
    chk("R6 clear beats tick", resetReq, 0);
    measure(P_FAST + 4, got);
    chk("R6 full period after clear", got, P_FAST);

    // R7 every non-normal mode holds the count cleared
    for (int m = 1; m < 4; m++) begin
      setCfg(1'b0, 1'b1);
      runQuiet(100, hits);
      cpuMode = 2'(m);
      runQuiet(200, hits);
      chk($sformatf("R7 mode %0d no request", m), hits, 0);
      cpuMode = 2'b00;
      @(negedge clk);
      measure(P_FAST + 4, got);
      chk($sformatf("R7 mode %0d full period after", m), got, P_FAST);
    end

    // R8 config change drops prescaler count, keeps final stage
    setCfg(1'b0, 1'b1);
    runQuiet(P_FAST - (1 << FAST) + 3, hits);
    chk("R8 no early request", hits, 0);
    rateSel = 1'b0;
    @(negedge clk);
    rateSel = 1'b1;
    @(negedge clk);
    measure(P_FAST, got);
    chk("R8 remaining ticks", got, 1 << FAST);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule